// File: doc/BRIEF.md
# Vector condition-to-integer bit packer

This block walks a vector of four-bit condition fields and turns each one into a single result bit. It then packs those bits into integer registers. A start pulse supplies the job:

- the vector length (1 to 64);
- a base field index and a flag saying whether the source steps through consecutive fields or stays on one;
- a base destination register and a flag saying whether the destination is a vector of registers or one register;
- a two-bit packing code;
- a four-bit select mask, a four-bit wanted pattern, and a reduce-kind bit.

One element is evaluated per clock. For each element the block reads a condition field through a combinational read port. It builds per-bit hits from the select mask and the wanted pattern, then reduces them by OR or by AND.

With a vector destination, results are gathered into a register-wide accumulator. The packing code sets how many results share one register. A register is written once, when its slots fill or when the last element is reached, and every bit beyond the packed results is written as zero. With a single destination register, all results land in consecutive bits from the least significant end. The final write is a read-modify-write, so bits at or above the vector length keep their old contents; byte enables cover only the bytes that hold result bits.

The controller has three states. IDLE is the rest state. RUN is entered from IDLE on an accepted start and processes one element per cycle. When the last element has been processed it moves to DONE. DONE lasts exactly one cycle and then returns to IDLE.

Top module: `cond_pack_engine`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `done` and `reg_wr_en` are 0.
- R2: With `src_vec`=1, element i reads condition field (`src_base` + i) modulo 128. With `src_vec`=0, every element reads field `src_base`.
- R3: For field bit k, hit k = `sel_mask[k]` AND (`want[k]` equals field bit k). The element result is the OR of the four hits when `any_mode`=1, and their AND when `any_mode`=0.
- R4: With `dst_vec`=1, P is 1, 2, 4 or 8 for `pack_code` 00, 01, 10 or 11. Element i goes to register (`dst_base` + i/P) modulo 128 at bit (i mod P), counted from bit 0. All other bits of that register are written as zero, and all byte enables are set.
- R5: With `dst_vec`=1, each register is written exactly once, when its P slots are filled or at the last element. A job therefore makes ceil(VL/P) writes. With `dst_vec`=0 a job makes exactly one write.
- R6: With `dst_vec`=0, result i lands in bit i of register `dst_base`. Bits at or above VL keep their previous value, and byte b is enabled only when 8*b < VL.
- R7: One element is processed per cycle. `done` is a one-cycle pulse VL+1 cycles after the start is accepted, one cycle after the final write. `busy` is high from the cycle after acceptance through the `done` cycle.
- R8: A `start` seen while `busy` is high is ignored, whatever its other inputs carry.
- R9: A `start` with `vl` equal to 0 or above 64 is ignored: the block stays in IDLE and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Job request pulse |
| vl | input | 7 | Vector length, valid 1..64 |
| src_base | input | 7 | First condition field index |
| src_vec | input | 1 | 1: step through fields; 0: reuse one field |
| dst_base | input | 7 | First destination register index |
| dst_vec | input | 1 | 1: vector of registers; 0: one register |
| pack_code | input | 2 | Results per register: 1, 2, 4 or 8 |
| sel_mask | input | 4 | Which field bits take part |
| want | input | 4 | Bit values to compare against |
| any_mode | input | 1 | 1: OR reduce; 0: AND reduce |
| fld_rd_idx | output | 7 | Condition field read index |
| fld_rd_data | input | 4 | Condition field read data (combinational) |
| reg_rd_idx | output | 7 | Integer register read index |
| reg_rd_data | input | 64 | Integer register read data (combinational) |
| reg_wr_en | output | 1 | Integer register write strobe |
| reg_wr_idx | output | 7 | Integer register write index |
| reg_wr_data | output | 64 | Integer register write data |
| reg_wr_be | output | 8 | Byte enables for the write |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the following corner cases:

- **Partial last register.** Nine elements at eight per register must end with a second register holding one bit and zeros above it. A packer that writes only on a full register would lose that tail; one that skips clearing would leave stale bits.
- **Single-register destination.** Lengths of 3 and 64 check that bits above VL survive the read-modify-write. A design that zeroes them, or mishandles the full 64-bit mask, corrupts the register.
- **AND reduce with a partial select mask.** This must always give 0, which catches a design that ignores the mask in AND mode.
- **Source wrap and timing.** A source base near the top of the field space checks the wrap. Stray starts during a run, and starts with illegal lengths, must change neither the written registers nor the `done` timing.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cpk_state_e;
endpackage

// File: rtl/cpk_reduce.sv
module cpk_reduce #(
    parameter int FIELD_W = 4
) (
    input  logic [FIELD_W-1:0] fld,
    input  logic [FIELD_W-1:0] sel_mask,
    input  logic [FIELD_W-1:0] want,
    input  logic               any_mode,
    output logic               res
);
    logic [FIELD_W-1:0] hit;

    for (genvar k = 0; k < FIELD_W; k++) begin : g_hit
        assign hit[k] = sel_mask[k] & ~(want[k] ^ fld[k]);
    end

    always_comb begin
        if (any_mode) res = |hit;
        else          res = &hit;
    end
endmodule

// File: rtl/cpk_ctrl.sv
module cpk_ctrl
    import cpk_pkg::*;
#(
    parameter int MAX_VL  = 64,
    parameter int FIDX_W  = 7,
    parameter int RIDX_W  = 7,
    parameter int FIELD_W = 4,
    localparam int VL_W   = $clog2(MAX_VL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VL_W-1:0]    vl,
    input  logic [FIDX_W-1:0]  src_base,
    input  logic               src_vec,
    input  logic [RIDX_W-1:0]  dst_base,
    input  logic               dst_vec,
    input  logic [1:0]         pack_code,
    input  logic [FIELD_W-1:0] sel_mask,
    input  logic [FIELD_W-1:0] want,
    input  logic               any_mode,
    output cpk_state_e         state,
    output logic               accept,
    output logic               run,
    output logic               busy,
    output logic               done,
    output logic               elem_last,
    output logic [VL_W-1:0]    elem_idx,
    output logic [VL_W-1:0]    vl_q,
    output logic [FIDX_W-1:0]  src_base_q,
    output logic               src_vec_q,
    output logic [RIDX_W-1:0]  dst_base_q,
    output logic               dst_vec_q,
    output logic [1:0]         code_q,
    output logic [FIELD_W-1:0] mask_q,
    output logic [FIELD_W-1:0] want_q,
    output logic               any_q
);
    cpk_state_e state_nx;
    logic       vl_ok;

    assign vl_ok  = (vl != '0) && (vl <= VL_W'(MAX_VL));
    assign accept = (state == ST_IDLE) && start && vl_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)    state_nx = ST_RUN;
            ST_RUN:  if (elem_last) state_nx = ST_DONE;
            ST_DONE:                state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run       = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        elem_last = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN: begin
                run       = 1'b1;
                busy      = 1'b1;
                elem_last = (elem_idx == vl_q - VL_W'(1));
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // job parameters captured on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q       <= '0;
            src_base_q <= '0;
            src_vec_q  <= 1'b0;
            dst_base_q <= '0;
            dst_vec_q  <= 1'b0;
            code_q     <= '0;
            mask_q     <= '0;
            want_q     <= '0;
            any_q      <= 1'b0;
        end else if (accept) begin
            vl_q       <= vl;
            src_base_q <= src_base;
            src_vec_q  <= src_vec;
            dst_base_q <= dst_base;
            dst_vec_q  <= dst_vec;
            code_q     <= pack_code;
            mask_q     <= sel_mask;
            want_q     <= want;
            any_q      <= any_mode;
        end
    end

    // element counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      elem_idx <= '0;
        else if (accept) elem_idx <= '0;
        else if (run)    elem_idx <= elem_idx + VL_W'(1);
    end
endmodule

// File: rtl/cpk_packer.sv
module cpk_packer #(
    parameter int XLEN   = 64,
    parameter int RIDX_W = 7,
    parameter int MAX_VL = 64,
    localparam int VL_W   = $clog2(MAX_VL + 1),
    localparam int SLOT_W = $clog2(XLEN),
    localparam int BYTES  = XLEN / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic              elem_last,
    input  logic [VL_W-1:0]   elem_idx,
    input  logic              res,
    input  logic              dst_vec,
    input  logic [1:0]        code,
    input  logic [RIDX_W-1:0] dst_base,
    input  logic [VL_W-1:0]   vl,
    input  logic [XLEN-1:0]   rd_data,
    output logic [RIDX_W-1:0] rd_idx,
    output logic              wr_en,
    output logic [RIDX_W-1:0] wr_idx,
    output logic [XLEN-1:0]   wr_data,
    output logic [BYTES-1:0]  wr_be
);
    logic [XLEN-1:0]   acc;
    logic [XLEN-1:0]   merged;
    logic [XLEN-1:0]   low_bits;
    logic [SLOT_W-1:0] pmask;
    logic [SLOT_W-1:0] slot;
    logic              full;
    logic              flush;

    assign pmask  = SLOT_W'((32'd1 << code) - 32'd1);
    assign slot   = dst_vec ? (elem_idx[SLOT_W-1:0] & pmask) : elem_idx[SLOT_W-1:0];
    assign full   = dst_vec && (slot == pmask);
    assign flush  = elem_last || full;
    assign merged = acc | (XLEN'(res) << slot);

    always_comb begin
        if (vl >= VL_W'(XLEN)) low_bits = '1;
        else                   low_bits = (XLEN'(1) << vl) - XLEN'(1);
    end

    assign rd_idx  = dst_base;
    assign wr_en   = run && flush;
    assign wr_idx  = dst_base + (dst_vec ? RIDX_W'(elem_idx >> code) : '0);
    assign wr_data = dst_vec ? merged : ((rd_data & ~low_bits) | merged);

    for (genvar b = 0; b < BYTES; b++) begin : g_be
        assign wr_be[b] = dst_vec || (vl > VL_W'(8 * b));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc <= '0;
        else if (clear) acc <= '0;
        else if (run)   acc <= flush ? '0 : merged;
    end
endmodule

// File: rtl/cond_pack_engine.sv
module cond_pack_engine
    import cpk_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int FIELD_W = 4,
    parameter int FIDX_W  = 7,
    parameter int RIDX_W  = 7,
    parameter int MAX_VL  = 64,
    localparam int VL_W   = $clog2(MAX_VL + 1),
    localparam int BYTES  = XLEN / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VL_W-1:0]    vl,
    input  logic [FIDX_W-1:0]  src_base,
    input  logic               src_vec,
    input  logic [RIDX_W-1:0]  dst_base,
    input  logic               dst_vec,
    input  logic [1:0]         pack_code,
    input  logic [FIELD_W-1:0] sel_mask,
    input  logic [FIELD_W-1:0] want,
    input  logic               any_mode,
    output logic [FIDX_W-1:0]  fld_rd_idx,
    input  logic [FIELD_W-1:0] fld_rd_data,
    output logic [RIDX_W-1:0]  reg_rd_idx,
    input  logic [XLEN-1:0]    reg_rd_data,
    output logic               reg_wr_en,
    output logic [RIDX_W-1:0]  reg_wr_idx,
    output logic [XLEN-1:0]    reg_wr_data,
    output logic [BYTES-1:0]   reg_wr_be,
    output logic               busy,
    output logic               done
);
    cpk_state_e         state;
    logic               accept;
    logic               run;
    logic               elem_last;
    logic [VL_W-1:0]    elem_idx;
    logic [VL_W-1:0]    vl_q;
    logic [FIDX_W-1:0]  src_base_q;
    logic               src_vec_q;
    logic [RIDX_W-1:0]  dst_base_q;
    logic               dst_vec_q;
    logic [1:0]         code_q;
    logic [FIELD_W-1:0] mask_q;
    logic [FIELD_W-1:0] want_q;
    logic               any_q;
    logic               elem_res;

    cpk_ctrl #(
        .MAX_VL (MAX_VL),
        .FIDX_W (FIDX_W),
        .RIDX_W (RIDX_W),
        .FIELD_W(FIELD_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vl        (vl),
        .src_base  (src_base),
        .src_vec   (src_vec),
        .dst_base  (dst_base),
        .dst_vec   (dst_vec),
        .pack_code (pack_code),
        .sel_mask  (sel_mask),
        .want      (want),
        .any_mode  (any_mode),
        .state     (state),
        .accept    (accept),
        .run       (run),
        .busy      (busy),
        .done      (done),
        .elem_last (elem_last),
        .elem_idx  (elem_idx),
        .vl_q      (vl_q),
        .src_base_q(src_base_q),
        .src_vec_q (src_vec_q),
        .dst_base_q(dst_base_q),
        .dst_vec_q (dst_vec_q),
        .code_q    (code_q),
        .mask_q    (mask_q),
        .want_q    (want_q),
        .any_q     (any_q)
    );

    assign fld_rd_idx = src_base_q + (src_vec_q ? FIDX_W'(elem_idx) : '0);

    cpk_reduce #(.FIELD_W(FIELD_W)) u_reduce (
        .fld     (fld_rd_data),
        .sel_mask(mask_q),
        .want    (want_q),
        .any_mode(any_q),
        .res     (elem_res)
    );

    cpk_packer #(
        .XLEN  (XLEN),
        .RIDX_W(RIDX_W),
        .MAX_VL(MAX_VL)
    ) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .run      (run),
        .elem_last(elem_last),
        .elem_idx (elem_idx),
        .res      (elem_res),
        .dst_vec  (dst_vec_q),
        .code     (code_q),
        .dst_base (dst_base_q),
        .vl       (vl_q),
        .rd_data  (reg_rd_data),
        .rd_idx   (reg_rd_idx),
        .wr_en    (reg_wr_en),
        .wr_idx   (reg_wr_idx),
        .wr_data  (reg_wr_data),
        .wr_be    (reg_wr_be)
    );
endmodule

// File: rtl/cpk_checker.sv
module cpk_checker #(
    parameter int FIDX_W = 7,
    parameter int BYTES  = 8,
    parameter int VL_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              run,
    input logic              busy,
    input logic              done,
    input logic              elem_last,
    input logic [VL_W-1:0]   elem_idx,
    input logic              src_vec_q,
    input logic              dst_vec_q,
    input logic [FIDX_W-1:0] fld_rd_idx,
    input logic              reg_wr_en,
    input logic [BYTES-1:0]  reg_wr_be
);
    AST_QUIET_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !reg_wr_en); // R1

    AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && src_vec_q |-> fld_rd_idx == FIDX_W'($past(fld_rd_idx) + 1'b1)); // R2

    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && !src_vec_q |-> $stable(fld_rd_idx)); // R2

    AST_VEC_FULL_BE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && dst_vec_q |-> &reg_wr_be); // R4

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(reg_wr_en)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        run && start && !elem_last |=> run && elem_idx == VL_W'($past(elem_idx) + 1'b1)); // R8
endmodule

bind cond_pack_engine cpk_checker #(
    .FIDX_W(FIDX_W),
    .BYTES (BYTES),
    .VL_W  (VL_W)
) u_cpk_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .run       (run),
    .busy      (busy),
    .done      (done),
    .elem_last (elem_last),
    .elem_idx  (elem_idx),
    .src_vec_q (src_vec_q),
    .dst_vec_q (dst_vec_q),
    .fld_rd_idx(fld_rd_idx),
    .reg_wr_en (reg_wr_en),
    .reg_wr_be (reg_wr_be)
);

// File: tb/cond_pack_engine_test.sv
module cond_pack_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl = '0;
    logic [6:0]  src_base = '0;
    logic        src_vec = 1'b0;
    logic [6:0]  dst_base = '0;
    logic        dst_vec = 1'b0;
    logic [1:0]  pack_code = '0;
    logic [3:0]  sel_mask = '0;
    logic [3:0]  want = '0;
    logic        any_mode = 1'b0;
    logic [6:0]  fld_rd_idx;
    logic [3:0]  fld_rd_data;
    logic [6:0]  reg_rd_idx;
    logic [63:0] reg_rd_data;
    logic        reg_wr_en;
    logic [6:0]  reg_wr_idx;
    logic [63:0] reg_wr_data;
    logic [7:0]  reg_wr_be;
    logic        busy;
    logic        done;

    logic [3:0]  cf [128];
    logic [63:0] rf [128];
    logic [63:0] exp_rf [128];
    int          wr_count = 0;
    int          checks = 0;
    int          fails = 0;
    bit          rf_seeded = 1'b0;

    always #5 clk = ~clk;

    cond_pack_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
        .src_base(src_base), .src_vec(src_vec), .dst_base(dst_base),
        .dst_vec(dst_vec), .pack_code(pack_code), .sel_mask(sel_mask),
        .want(want), .any_mode(any_mode), .fld_rd_idx(fld_rd_idx),
        .fld_rd_data(fld_rd_data), .reg_rd_idx(reg_rd_idx),
        .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en),
        .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .reg_wr_be(reg_wr_be), .busy(busy), .done(done)
    );

    assign fld_rd_data = cf[fld_rd_idx];
    assign reg_rd_data = rf[reg_rd_idx];

    // register file model: seeded once, then written only by the block
    always @(posedge clk) begin
        if (!rf_seeded) begin
            for (int r = 0; r < 128; r++) rf[r] <= {$urandom, $urandom};
            rf_seeded <= 1'b1;
        end else if (reg_wr_en) begin
            for (int b = 0; b < 8; b++)
                if (reg_wr_be[b]) rf[reg_wr_idx][8*b +: 8] <= reg_wr_data[8*b +: 8];
            wr_count <= wr_count + 1;
        end
    end

    function automatic logic elem_bit(logic [3:0] f, logic [3:0] m, logic [3:0] w, logic any);
        logic [3:0] h;
        h = m & ~(w ^ f);
        return any ? |h : &h;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] expv);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic compare_rf(string tag);
        for (int r = 0; r < 128; r++) begin
            checks++;
            if (rf[r] !== exp_rf[r]) begin
                fails++;
                $display("FAIL %s reg %0d got %h expected %h", tag, r, rf[r], exp_rf[r]);
            end
        end
    endtask

    task automatic run_op(int n, int sb, bit sv, int db, bit dv, int code,
                          logic [3:0] m, logic [3:0] w, bit any, bit poke);
        int p, cnt, wc0, nwr;
        logic r;
        for (int f = 0; f < 128; f++) cf[f] = 4'($urandom);
        for (int k = 0; k < 128; k++) exp_rf[k] = rf[k];
        p = 1 << code;
        for (int i = 0; i < n; i++) begin
            r = elem_bit(cf[sv ? (sb + i) % 128 : sb], m, w, any);
            if (dv) begin
                if (i % p == 0) exp_rf[(db + i / p) % 128] = '0;
                exp_rf[(db + i / p) % 128][i % p] = r;
            end else begin
                exp_rf[db][i] = r;
            end
        end
        nwr = dv ? (n + p - 1) / p : 1;
        @(negedge clk);
        vl = 7'(n); src_base = 7'(sb); src_vec = sv; dst_base = 7'(db); dst_vec = dv;
        pack_code = 2'(code); sel_mask = m; want = w; any_mode = any; start = 1'b1;
        wc0 = wr_count;
        cnt = 0;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        if (poke) begin
            // stray request with unrelated settings while running (R8)
            vl = 7'd3; src_base = 7'($urandom); dst_base = 7'($urandom);
            dst_vec = ~dv; pack_code = ~pack_code; sel_mask = ~m; any_mode = ~any;
            start = 1'b1;
        end
        while (!done && cnt < 200) begin
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end
        check("R7 done latency", 64'(cnt), 64'(n + 1));
        check("R5 write count", 64'(wr_count - wc0), 64'(nwr));
        @(negedge clk);
        check("R7 done/busy drop", {62'd0, done, busy}, 64'd0);
        compare_rf(dv ? (poke ? "R8 R2 R3 R4" : "R2 R3 R4")
                      : (poke ? "R8 R2 R3 R6" : "R2 R3 R6"));
    endtask

    task automatic bad_start(int n);
        int wc0;
        for (int k = 0; k < 128; k++) exp_rf[k] = rf[k];
        @(negedge clk);
        vl = 7'(n); dst_vec = 1'b1; start = 1'b1;
        wc0 = wr_count;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after illegal length", 64'(busy), 64'd0);
        repeat (2) @(negedge clk);
        check("R9 no writes", 64'(wr_count - wc0), 64'd0);
        check("R9 no done", 64'(done), 64'd0);
        compare_rf("R9");
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {61'd0, busy, done, reg_wr_en}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {61'd0, busy, done, reg_wr_en}, 64'd0);

        run_op(64, 10, 1, 5, 0, 0, 4'b1011, 4'b0010, 1, 0);    // full scalar dst
        run_op(3, 40, 1, 9, 0, 0, 4'b1111, 4'b0101, 1, 0);     // bits above 3 kept
        run_op(5, 77, 0, 20, 0, 0, 4'b0110, 4'b0110, 0, 0);    // one source field
        run_op(1, 0, 1, 30, 1, 0, 4'b0001, 4'b0000, 1, 0);
        run_op(64, 3, 1, 60, 1, 0, 4'b1100, 4'b0100, 1, 0);    // 64 registers
        run_op(9, 50, 1, 2, 1, 3, 4'b1111, 4'b1010, 1, 0);     // partial tail
        run_op(7, 60, 1, 100, 1, 1, 4'b0011, 4'b0001, 1, 0);
        run_op(6, 61, 1, 110, 1, 2, 4'b1111, 4'b0000, 0, 0);   // AND, full mask
        run_op(12, 5, 1, 70, 1, 0, 4'b0101, 4'b1111, 0, 0);    // AND, partial mask
        run_op(20, 120, 1, 125, 1, 2, 4'b1001, 4'b1000, 1, 0); // both wrap
        run_op(16, 33, 1, 44, 1, 3, 4'b1110, 4'b0110, 1, 1);   // stray start
        run_op(10, 7, 1, 88, 0, 2, 4'b0111, 4'b0011, 1, 1);    // stray start
        bad_start(0);
        bad_start(65);
        bad_start(127);

        for (int t = 0; t < 40; t++) begin
            run_op(1 + int'($urandom % 64), int'($urandom % 128), 1'($urandom),
                   int'($urandom % 128), 1'($urandom), int'($urandom % 4),
                   4'($urandom), 4'($urandom), 1'($urandom), ($urandom % 4) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule